// File: doc/BRIEF.md
# Two-Priority Process Scheduler

This block dispatches lightweight processes at two priority levels. Each level has a first-in first-out ready queue. The queue is a linked list threaded through a small workspace memory: each process descriptor owns one workspace slot, which holds a link word and the saved instruction pointer. A front register and a back register track each list. A reserved all-ones workspace pointer marks "no process". A process enters a queue through a run request that names its workspace pointer, its priority and its resume instruction pointer.

The running process leaves the processor in one of three ways:
- It blocks (a deschedule request).
- It is preempted by a newly ready high-priority process. The preempted low-priority process is parked in a shadow register.
- It reaches a jump or loop-end point after its low-priority timeslice has run out. It is then sent to the back of the low queue, with its current instruction pointer written into its workspace slot.

A timeslice period is `SLICE_TICKS` high-priority timer ticks. A low-priority process is switched out at a jump once two period boundaries have passed since it was dispatched.

Whenever nothing runs and no run request arrives in that cycle, the block chooses the next process in this order:
1. The front of the high queue.
2. The parked low process.
3. The front of the low queue.

On the next clock edge it presents that process's descriptor and its restored instruction pointer, together with a one-cycle switch strobe. When no process is running, waiting or parked, the idle output is high.

Top module: `proc_sched`

## Requirements
- R1: After reset `idle_o` is 1, `cur_valid_o` is 0 and `switch_o` is 0.
- R2: Processes of one priority are dispatched in the order their run requests were accepted. A process requeued after its timeslice joins the back of the low queue.
- R3: Priority encoding is 0 = high, 1 = low. When a dispatch happens and the high queue holds a process, that process is chosen before the parked low process and before the low queue.
- R4: A running high-priority process stays current, with unchanged descriptor, until a deschedule request. Jumps, ticks and run requests have no effect on it.
- R5: A high-priority run request accepted while a low-priority process runs (with no deschedule in that cycle) drops `cur_valid_o` at the next edge.
- R6: A preempted low-priority process resumes before any process in the low queue, once the high queue is empty. Its `cur_iptr_o` equals `exec_iptr_i` from the preempting cycle.
- R7: A jump by a running low-priority process retires it only when two period boundaries have passed since its dispatch. A period is `SLICE_TICKS` ticks of a free-running tick counter, which starts at 0 at reset. A jump with fewer boundaries, or a jump in the same cycle as a run request, has no effect.
- R8: A process retired by its timeslice is later dispatched with `cur_iptr_o` equal to the `exec_iptr_i` it presented at the retiring jump. A process from a run request is dispatched with the `run_iptr_i` it was given.
- R9: A deschedule request while a process runs clears `cur_valid_o` at the next edge. The process is not requeued. A deschedule request with no process running is ignored.
- R10: A dispatch happens at an edge where no process was current and no run request is present. `cur_valid_o` and `switch_o` rise together, and `switch_o` lasts one cycle. A run request every cycle holds dispatch off.
- R11: `idle_o` is 1 exactly when no process is current, both queues are empty and no preempted process is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_valid_i | input | 1 | Run request: enqueue a descriptor |
| run_wptr_i | input | WPTR_W | Workspace pointer of the process made ready (all ones reserved) |
| run_pri_i | input | 1 | Priority of the process made ready, 0 high, 1 low |
| run_iptr_i | input | IPTR_W | Instruction pointer to resume the process at |
| desched_i | input | 1 | Current process blocks |
| jump_i | input | 1 | Current process is at a jump or loop-end point |
| exec_iptr_i | input | IPTR_W | Instruction pointer of the running process, saved on preemption or requeue |
| hi_tick_i | input | 1 | High-priority timer tick |
| cur_valid_o | output | 1 | A process is current |
| cur_wptr_o | output | WPTR_W | Workspace pointer of the current process |
| cur_pri_o | output | 1 | Priority of the current process |
| cur_iptr_o | output | IPTR_W | Restored instruction pointer of the current process |
| switch_o | output | 1 | Context-switch strobe, one cycle per dispatch |
| idle_o | output | 1 | Nothing current, queued or parked |

## Verification
A run request, a deschedule, a preempting run or an expired jump changes the queues and `cur_valid_o` at the first clock edge after it is presented. A dispatch needs one further edge: `cur_valid_o`, the descriptor, the restored pointer and `switch_o` all appear together one edge after the cycle in which nothing was current and no run request was present. The bench's reference model steps at every rising edge from the same inputs. It compares all outputs half a cycle later, while inputs change only on falling edges. The directed checks count those edges explicitly before sampling.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    PRI_HI = 1'b0,
    PRI_LO = 1'b1
  } prio_e;
endpackage

// File: rtl/sched_ws_mem.sv
// Workspace slots: a link word and a saved instruction pointer per descriptor.
module sched_ws_mem #(
  parameter int WPTR_W = 5,
  parameter int IPTR_W = 16,
  localparam int DEPTH = 1 << WPTR_W
) (
  input  logic                   clk_i,
  input  logic                   enq_i,
  input  logic [WPTR_W-1:0]      enq_wptr_i,
  input  logic [IPTR_W-1:0]      enq_iptr_i,
  input  logic                   link_we_i,
  input  logic [WPTR_W-1:0]      link_addr_i,
  input  logic [1:0][WPTR_W-1:0] rd_wptr_i,
  output logic [1:0][WPTR_W-1:0] link_o,
  output logic [1:0][IPTR_W-1:0] iptr_o
);
  localparam logic [WPTR_W-1:0] NOT_PROC = '1;

  logic [WPTR_W-1:0] link_mem [DEPTH];
  logic [IPTR_W-1:0] iptr_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (enq_i) begin
      link_mem[enq_wptr_i] <= NOT_PROC;
      iptr_mem[enq_wptr_i] <= enq_iptr_i;
    end
    // old back entry now points at the new tail
    if (link_we_i) link_mem[link_addr_i] <= enq_wptr_i;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign link_o[p] = link_mem[rd_wptr_i[p]];
    assign iptr_o[p] = iptr_mem[rd_wptr_i[p]];
  end
endmodule

// File: rtl/sched_queue.sv
// Front/back pointer pair of one ready list.
module sched_queue #(
  parameter int WPTR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_i,
  input  logic [WPTR_W-1:0] enq_wptr_i,
  input  logic              deq_i,
  input  logic [WPTR_W-1:0] link_i,
  output logic [WPTR_W-1:0] front_o,
  output logic [WPTR_W-1:0] back_o,
  output logic              empty_o
);
  localparam logic [WPTR_W-1:0] NOT_PROC = '1;

  logic [WPTR_W-1:0] front_q, back_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q <= NOT_PROC;
      back_q  <= NOT_PROC;
    end else if (enq_i) begin
      back_q <= enq_wptr_i;
      if (front_q == NOT_PROC) front_q <= enq_wptr_i;
    end else if (deq_i && front_q != NOT_PROC) begin
      if (front_q == back_q) begin
        front_q <= NOT_PROC;
        back_q  <= NOT_PROC;
      end else begin
        front_q <= link_i;
      end
    end
  end

  assign front_o = front_q;
  assign back_o  = back_q;
  assign empty_o = (front_q == NOT_PROC);
endmodule

// File: rtl/sched_slice.sv
// Free-running period counter; counts period boundaries while a process runs.
module sched_slice #(
  parameter int SLICE_TICKS = 1024,
  localparam int CW = (SLICE_TICKS > 2) ? $clog2(SLICE_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic expired_o
);
  localparam logic [CW-1:0] LAST = CW'(SLICE_TICKS - 1);

  logic [CW-1:0] period_q;
  logic [1:0]    bounds_q;
  logic          wrap;

  assign wrap = tick_i && (period_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      bounds_q <= '0;
    end else begin
      if (tick_i) period_q <= wrap ? '0 : period_q + 1'b1;
      if (clear_i)                        bounds_q <= '0;
      else if (wrap && bounds_q != 2'd2)  bounds_q <= bounds_q + 2'd1;
    end
  end

  assign expired_o = (bounds_q == 2'd2);
endmodule

// File: rtl/proc_sched.sv
module proc_sched
  import sched_pkg::*;
#(
  parameter int WPTR_W      = 5,
  parameter int IPTR_W      = 16,
  parameter int SLICE_TICKS = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_valid_i,
  input  logic [WPTR_W-1:0] run_wptr_i,
  input  logic              run_pri_i,
  input  logic [IPTR_W-1:0] run_iptr_i,
  input  logic              desched_i,
  input  logic              jump_i,
  input  logic [IPTR_W-1:0] exec_iptr_i,
  input  logic              hi_tick_i,
  output logic              cur_valid_o,
  output logic [WPTR_W-1:0] cur_wptr_o,
  output logic              cur_pri_o,
  output logic [IPTR_W-1:0] cur_iptr_o,
  output logic              switch_o,
  output logic              idle_o
);
  logic              cur_valid_q, cur_pri_q, switch_q;
  logic [WPTR_W-1:0] cur_wptr_q;
  logic [IPTR_W-1:0] cur_iptr_q;
  logic              sh_valid_q;
  logic [WPTR_W-1:0] sh_wptr_q;
  logic [IPTR_W-1:0] sh_iptr_q;

  logic [1:0]              q_enq, q_deq, q_empty;
  logic [1:0][WPTR_W-1:0]  q_front, q_back, q_link;
  logic [1:0][IPTR_W-1:0]  q_iptr;

  logic              expired, retire_blk, retire_slice, preempt;
  logic              enq_valid, enq_pri;
  logic [WPTR_W-1:0] enq_wptr;
  logic [IPTR_W-1:0] enq_iptr;
  logic              slot, pick_hi, pick_sh, pick_lo;

  // retire paths of the current process
  assign retire_blk   = cur_valid_q && desched_i;
  assign retire_slice = cur_valid_q && !desched_i && jump_i && !run_valid_i &&
                        (cur_pri_q == PRI_LO) && expired;
  assign preempt      = cur_valid_q && !desched_i && run_valid_i &&
                        (run_pri_i == PRI_HI) && (cur_pri_q == PRI_LO);

  // single enqueue port: a run request, or a timeslice requeue when none
  assign enq_valid = run_valid_i || retire_slice;
  assign enq_pri   = run_valid_i ? run_pri_i  : PRI_LO;
  assign enq_wptr  = run_valid_i ? run_wptr_i : cur_wptr_q;
  assign enq_iptr  = run_valid_i ? run_iptr_i : exec_iptr_i;

  // dispatch order: high queue, parked low process, low queue
  assign slot    = !cur_valid_q && !run_valid_i;
  assign pick_hi = slot && !q_empty[PRI_HI];
  assign pick_sh = slot &&  q_empty[PRI_HI] && sh_valid_q;
  assign pick_lo = slot &&  q_empty[PRI_HI] && !sh_valid_q && !q_empty[PRI_LO];

  assign q_deq[PRI_HI] = pick_hi;
  assign q_deq[PRI_LO] = pick_lo;

  for (genvar p = 0; p < 2; p++) begin : g_q
    assign q_enq[p] = enq_valid && (enq_pri == 1'(p));
    sched_queue #(.WPTR_W(WPTR_W)) u_queue (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .enq_i     (q_enq[p]),
      .enq_wptr_i(enq_wptr),
      .deq_i     (q_deq[p]),
      .link_i    (q_link[p]),
      .front_o   (q_front[p]),
      .back_o    (q_back[p]),
      .empty_o   (q_empty[p])
    );
  end

  sched_ws_mem #(.WPTR_W(WPTR_W), .IPTR_W(IPTR_W)) u_ws (
    .clk_i      (clk_i),
    .enq_i      (enq_valid),
    .enq_wptr_i (enq_wptr),
    .enq_iptr_i (enq_iptr),
    .link_we_i  (enq_valid && !q_empty[enq_pri]),
    .link_addr_i(q_back[enq_pri]),
    .rd_wptr_i  (q_front),
    .link_o     (q_link),
    .iptr_o     (q_iptr)
  );

  sched_slice #(.SLICE_TICKS(SLICE_TICKS)) u_slice (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (hi_tick_i),
    .clear_i  (!cur_valid_q),
    .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_valid_q <= 1'b0;
      cur_pri_q   <= PRI_LO;
      cur_wptr_q  <= '0;
      cur_iptr_q  <= '0;
      switch_q    <= 1'b0;
    end else begin
      switch_q <= pick_hi || pick_sh || pick_lo;
      if (pick_hi) begin
        cur_valid_q <= 1'b1;
        cur_pri_q   <= PRI_HI;
        cur_wptr_q  <= q_front[PRI_HI];
        cur_iptr_q  <= q_iptr[PRI_HI];
      end else if (pick_sh) begin
        cur_valid_q <= 1'b1;
        cur_pri_q   <= PRI_LO;
        cur_wptr_q  <= sh_wptr_q;
        cur_iptr_q  <= sh_iptr_q;
      end else if (pick_lo) begin
        cur_valid_q <= 1'b1;
        cur_pri_q   <= PRI_LO;
        cur_wptr_q  <= q_front[PRI_LO];
        cur_iptr_q  <= q_iptr[PRI_LO];
      end else if (retire_blk || retire_slice || preempt) begin
        cur_valid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_valid_q <= 1'b0;
      sh_wptr_q  <= '0;
      sh_iptr_q  <= '0;
    end else if (preempt) begin
      sh_valid_q <= 1'b1;
      sh_wptr_q  <= cur_wptr_q;
      sh_iptr_q  <= exec_iptr_i;
    end else if (pick_sh) begin
      sh_valid_q <= 1'b0;
    end
  end

  assign cur_valid_o = cur_valid_q;
  assign cur_wptr_o  = cur_wptr_q;
  assign cur_pri_o   = cur_pri_q;
  assign cur_iptr_o  = cur_iptr_q;
  assign switch_o    = switch_q;
  assign idle_o      = !cur_valid_q && (&q_empty) && !sh_valid_q;
endmodule

// File: rtl/proc_sched_chk.sv
module proc_sched_chk #(
  parameter int WPTR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_valid_i,
  input logic              run_pri_i,
  input logic              desched_i,
  input logic              cur_valid_o,
  input logic [WPTR_W-1:0] cur_wptr_o,
  input logic              cur_pri_o,
  input logic              switch_o,
  input logic              idle_o
);
  assert_switch_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> cur_valid_o);

  assert_switch_from_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> $past(!cur_valid_o));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !cur_valid_o);

  assert_desc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_o && !switch_o) |-> ($stable(cur_wptr_o) && $stable(cur_pri_o)));

  assert_hi_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_o && cur_pri_o == 1'b0 && !desched_i) |=> (cur_valid_o && !switch_o));

  assert_preempt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_o && cur_pri_o == 1'b1 && run_valid_i && run_pri_i == 1'b0 && !desched_i)
    |=> !cur_valid_o);

  assert_desched_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_o && desched_i) |=> !cur_valid_o);

  assert_run_no_slice_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_o && run_valid_i && !desched_i && !(run_pri_i == 1'b0 && cur_pri_o == 1'b1))
    |=> cur_valid_o);
endmodule

bind proc_sched proc_sched_chk #(.WPTR_W(WPTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_valid_i(run_valid_i),
  .run_pri_i  (run_pri_i),
  .desched_i  (desched_i),
  .cur_valid_o(cur_valid_o),
  .cur_wptr_o (cur_wptr_o),
  .cur_pri_o  (cur_pri_o),
  .switch_o   (switch_o),
  .idle_o     (idle_o)
);

// File: tb/tb_proc_sched.sv
`timescale 1ns/1ps
module tb_proc_sched;
  localparam int WPTR_W = 5;
  localparam int IPTR_W = 16;
  localparam int SL     = 4;
  localparam int NSLOT  = (1 << WPTR_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic run_valid_i = 0, run_pri_i = 0, desched_i = 0, jump_i = 0, hi_tick_i = 0;
  logic [WPTR_W-1:0] run_wptr_i = '0;
  logic [IPTR_W-1:0] run_iptr_i = '0, exec_iptr_i = '0;
  logic cur_valid_o, cur_pri_o, switch_o, idle_o;
  logic [WPTR_W-1:0] cur_wptr_o;
  logic [IPTR_W-1:0] cur_iptr_o;

  always #2 clk_i = ~clk_i;

  proc_sched #(.WPTR_W(WPTR_W), .IPTR_W(IPTR_W), .SLICE_TICKS(SL)) dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int hq[$], lq[$];
  int ipt[NSLOT+1];
  bit m_v, m_p, m_sw, m_sh;
  int m_w, m_ip, m_shw, m_ship, m_pc, m_bnd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hq.delete(); lq.delete();
      m_v = 0; m_p = 1; m_sw = 0; m_sh = 0; m_w = 0; m_ip = 0; m_pc = 0; m_bnd = 0;
    end else begin
      bit des, rs, pre, slot;
      des  = m_v && desched_i;
      rs   = m_v && !desched_i && jump_i && m_p && (m_bnd == 2) && !run_valid_i;
      pre  = m_v && !desched_i && run_valid_i && !run_pri_i && m_p;
      slot = !m_v && !run_valid_i;
      if (!m_v) m_bnd = 0;
      else if (hi_tick_i && m_pc == SL-1 && m_bnd < 2) m_bnd++;
      if (hi_tick_i) m_pc = (m_pc + 1) % SL;
      m_sw = 0;
      if (slot) begin
        if (hq.size() > 0) begin
          m_w = hq.pop_front(); m_p = 0; m_ip = ipt[m_w]; m_v = 1; m_sw = 1;
        end else if (m_sh) begin
          m_w = m_shw; m_p = 1; m_ip = m_ship; m_v = 1; m_sw = 1; m_sh = 0;
        end else if (lq.size() > 0) begin
          m_w = lq.pop_front(); m_p = 1; m_ip = ipt[m_w]; m_v = 1; m_sw = 1;
        end
      end
      if (run_valid_i) begin
        ipt[run_wptr_i] = run_iptr_i;
        if (run_pri_i) lq.push_back(run_wptr_i); else hq.push_back(run_wptr_i);
      end
      if (rs)  begin ipt[m_w] = exec_iptr_i; lq.push_back(m_w); m_v = 0; end
      if (pre) begin m_sh = 1; m_shw = m_w; m_ship = exec_iptr_i; m_v = 0; end
      if (des) m_v = 0;
    end
  end

  // per-cycle comparison, half a cycle after each rising edge
  always @(negedge clk_i) if (rst_ni && !done) begin
    check_eq("R9 cur_valid", cur_valid_o, m_v);
    check_eq("R10 switch", switch_o, m_sw);
    check_eq("R11 idle", idle_o, !m_v && hq.size() == 0 && lq.size() == 0 && !m_sh);
    if (cur_valid_o && m_v) begin
      check_eq("R2 wptr", cur_wptr_o, m_w);
      check_eq("R3 pri", cur_pri_o, m_p);
      check_eq("R8 iptr", cur_iptr_o, m_ip);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(); @(negedge clk_i); endtask
  task automatic clr();
    run_valid_i = 0; desched_i = 0; jump_i = 0; hi_tick_i = 0;
  endtask
  task automatic run(int w, bit p, int ip);
    run_valid_i = 1; run_wptr_i = w[WPTR_W-1:0]; run_pri_i = p; run_iptr_i = ip[IPTR_W-1:0];
  endtask
  task automatic expect_cur(string tag, int w, bit p, int ip);
    check_eq({tag, " valid"}, cur_valid_o, 1);
    check_eq({tag, " wptr"}, cur_wptr_o, w);
    check_eq({tag, " pri"}, cur_pri_o, p);
    check_eq({tag, " iptr"}, cur_iptr_o, ip);
  endtask

  bit busy[NSLOT];

  initial begin
    repeat (3) step();
    check_eq("R1 idle", idle_o, 1);
    check_eq("R1 valid", cur_valid_o, 0);
    check_eq("R1 switch", switch_o, 0);
    rst_ni = 1;
    step();
    // FIFO fill of low queue
    run(1, 1, 100); step(); run(2, 1, 200); step(); run(3, 1, 300); step(); clr();
    check_eq("R10 no dispatch during runs", cur_valid_o, 0);
    step();
    expect_cur("R2 first", 1, 1, 100);
    check_eq("R10 strobe", switch_o, 1);
    step();
    check_eq("R10 strobe one cycle", switch_o, 0);
    // jump before slice expiry
    jump_i = 1; exec_iptr_i = 120; step(); clr();
    check_eq("R7 early jump ignored", cur_valid_o, 1);
    hi_tick_i = 1; repeat (2*SL) step(); clr();
    jump_i = 1; exec_iptr_i = 150; step(); clr();
    check_eq("R7 expired jump retires", cur_valid_o, 0);
    step();
    expect_cur("R2 second", 2, 1, 200);
    // preemption
    run(5, 0, 500); exec_iptr_i = 250; step(); clr();
    check_eq("R5 preempt", cur_valid_o, 0);
    step();
    expect_cur("R5 high runs", 5, 0, 500);
    hi_tick_i = 1; jump_i = 1; repeat (3*SL) step(); clr();
    expect_cur("R4 high not sliced", 5, 0, 500);
    run(6, 0, 600); step(); clr();
    expect_cur("R4 high keeps on run", 5, 0, 500);
    desched_i = 1; step(); clr();
    check_eq("R9 desched", cur_valid_o, 0);
    step();
    expect_cur("R3 high before parked", 6, 0, 600);
    desched_i = 1; step(); clr(); step();
    expect_cur("R6 parked resumes", 2, 1, 250);
    desched_i = 1; step(); clr(); step();
    expect_cur("R2 third", 3, 1, 300);
    desched_i = 1; step(); clr(); step();
    expect_cur("R8 requeued iptr", 1, 1, 150);
    desched_i = 1; step(); clr();
    check_eq("R11 idle again", idle_o, 1);
    desched_i = 1; step(); clr();
    check_eq("R9 desched idle ignored", idle_o, 1);
    // dispatch stall under back-to-back runs
    run(7, 1, 700); step(); run(8, 1, 800); step(); run(9, 1, 900); step(); clr();
    check_eq("R10 stall", cur_valid_o, 0);
    step();
    expect_cur("R10 after gap", 7, 1, 700);
    hi_tick_i = 1; repeat (2*SL) step(); clr();
    jump_i = 1; exec_iptr_i = 710; run(11, 1, 1100); step(); clr();
    expect_cur("R7 jump with run ignored", 7, 1, 700);
    jump_i = 1; exec_iptr_i = 720; step(); clr(); step();
    expect_cur("R2 slice rotate", 8, 1, 800);

    // random phase from a fresh reset
    rst_ni = 0; step(); rst_ni = 1; step();
    for (int i = 0; i < 4000; i++) begin
      clr();
      if ($urandom_range(0, 9) < 3) begin
        int w;
        w = $urandom_range(0, NSLOT-1);
        if (!busy[w]) begin
          busy[w] = 1;
          run(w, 1'($urandom_range(0, 3) == 0), $urandom_range(0, 65535));
        end
      end
      if (cur_valid_o && $urandom_range(0, 9) < 2) begin
        desched_i = 1;
        busy[cur_wptr_o] = 0;
      end
      jump_i      = ($urandom_range(0, 9) < 3);
      hi_tick_i   = ($urandom_range(0, 1) == 1);
      exec_iptr_i = IPTR_W'($urandom_range(0, 65535));
      step();
    end
    clr();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule